// File: doc/BRIEF.md
# Load Data Width and Saturation Formatter

This block is the last datapath stage of a load pipe. It takes the raw bytes a memory read returned at the operation width (byte, half, word or double) and turns them into one register element at the destination element width (8, 16, 32 or 64 bits). Before any width handling, the bytes within the operation width may be reversed. The block then either adjusts the width plainly or clamps the value into the destination range, treating it as unsigned or as signed.

The byte order is reversed when the opcode's reverse flag and the machine's little-endian bit are equal. This folds the reversed-load opcodes and the machine's byte order into one decision. Saturation is applied from the operation width down to a separately chosen destination width, so a double load can be clamped into a byte element, for example. Each accepted input produces one result exactly one clock later. The result is right-aligned on a 64-bit bus with every bit above the destination width cleared. Placing the element into a packed register file is left to the consumer.

Top module: `ldfmt_stage`

## Requirements
- R1: While reset is held and on the first clock after it is released, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` equals the value `in_valid` had at the previous rising clock edge. A result sampled with `in_valid`=1 appears on `out_data` one clock later.
- R3: When `in_rev` equals `in_le`, the bytes inside the operation width are reversed: byte k of the result is byte n-1-k of the input, where n is the operation width in bytes. Input bits above the operation width never affect the result.
- R4: When `in_rev` differs from `in_le`, the bytes inside the operation width keep their positions.
- R5: With `in_sat`=0, the (possibly reversed) value is zero-extended or truncated from the operation width to the destination width.
- R6: With `in_sat`=1 and `in_signed`=0, the value is taken as unsigned at the operation width. If it exceeds 2^w-1 for destination width w, the result is 2^w-1; otherwise the result is the value itself.
- R7: With `in_sat`=1 and `in_signed`=1, the value is taken as signed at the operation width and clamped to the range from -2^(w-1) to 2^(w-1)-1. A negative result is written in w-bit two's complement, so a value that fits, such as an 8-bit 0x80 widened into 16 bits, becomes 0xFF80.
- R8: The width codes on `in_op_w` and `in_dst_w` are 0 for 8 bits, 1 for 16 bits, 2 for 32 bits and 3 for 64 bits. `out_data` bits at and above the destination width are always 0.
- R9: A clock with `in_valid`=0 leaves `out_data` unchanged, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge |
| in_valid | input | 1 | Input qualifier |
| in_data | input | 64 | Raw load data, right-aligned at the operation width |
| in_op_w | input | 2 | Operation width code |
| in_dst_w | input | 2 | Destination element width code |
| in_rev | input | 1 | Opcode byte-reverse flag |
| in_le | input | 1 | Machine little-endian state bit |
| in_sat | input | 1 | Saturation enable |
| in_signed | input | 1 | Saturation signedness (1 = signed) |
| out_valid | output | 1 | Result qualifier |
| out_data | output | 64 | Formatted element, right-aligned, upper bits zero |

## Verification
Every result is due exactly one rising edge after the edge that samples its input. The bench applies each input on a falling edge and compares `out_valid` and `out_data` on the following falling edge, which is halfway between the capturing edge and the next one. For the hold behaviour, the bench drives an idle cycle with altered inputs and reads the output on the next falling edge. There it expects the previous result unchanged and `out_valid` low.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;

  localparam int unsigned LDF_DATA_W = 64;
  localparam int unsigned LDF_BYTES  = LDF_DATA_W / 8;
  localparam int unsigned LDF_NCODES = 4;

  typedef enum logic [1:0] {
    EW_8  = 2'd0,
    EW_16 = 2'd1,
    EW_32 = 2'd2,
    EW_64 = 2'd3
  } ew_code_e;

  // Ones in the low (8 << code) bits.
  function automatic logic [LDF_DATA_W-1:0] ew_mask(input logic [1:0] code);
    logic [LDF_DATA_W-1:0] m;
    m = '0;
    for (int b = 0; b < LDF_DATA_W; b++) begin
      if (b < (8 << code)) m[b] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/ldfmt_swap.sv
module ldfmt_swap
  import ldfmt_pkg::*;
#(
  parameter int unsigned DATA_W = LDF_DATA_W
) (
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        op_w,
  input  logic              do_swap,
  output logic [DATA_W-1:0] dout
);

  localparam int unsigned NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] swapped [LDF_NCODES];
  logic [DATA_W-1:0] masked;

  assign masked = din & ew_mask(op_w);

  // One reversal network per operation width.
  for (genvar c = 0; c < LDF_NCODES; c++) begin : g_width
    localparam int unsigned NB = 1 << c;
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      if (b < NB) begin : g_in
        assign swapped[c][b*8 +: 8] = din[(NB-1-b)*8 +: 8];
      end else begin : g_out
        assign swapped[c][b*8 +: 8] = 8'h00;
      end
    end
  end

  always_comb begin
    if (do_swap) dout = swapped[op_w];
    else         dout = masked;
  end

  // R3
  always_comb begin
    if (op_w == EW_8) begin
      byte_ident_chk: assert (dout == {{(DATA_W-8){1'b0}}, din[7:0]});
    end
  end

endmodule

// File: rtl/ldfmt_conv.sv
module ldfmt_conv
  import ldfmt_pkg::*;
#(
  parameter int unsigned DATA_W = LDF_DATA_W
) (
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        op_w,
  input  logic [1:0]        dst_w,
  input  logic              sat,
  input  logic              sgn,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] op_mask;
  logic [DATA_W-1:0] dst_mask;
  logic [DATA_W-1:0] half_mask;
  logic [DATA_W-1:0] sext;
  logic [DATA_W-1:0] upper;
  logic              sign_bit;
  logic              fits_s;
  logic              fits_u;
  logic [DATA_W-1:0] sat_u;
  logic [DATA_W-1:0] sat_s;

  always_comb begin
    op_mask   = ew_mask(op_w);
    dst_mask  = ew_mask(dst_w);
    half_mask = dst_mask >> 1;
    sign_bit  = din[(8 << op_w) - 1];
    sext      = (din & op_mask) | (sign_bit ? ~op_mask : '0);
    upper     = sext & ~half_mask;
    fits_s    = (upper == '0) || (upper == ~half_mask);
    fits_u    = ((din & op_mask & ~dst_mask) == '0);

    sat_u = fits_u ? (din & op_mask) : dst_mask;

    if (fits_s)        sat_s = sext & dst_mask;
    else if (sign_bit) sat_s = (~half_mask) & dst_mask;
    else               sat_s = half_mask;

    if (!sat)     dout = din & op_mask & dst_mask;
    else if (sgn) dout = sat_s;
    else          dout = sat_u & dst_mask;
  end

  // R6
  always_comb begin
    if (sat && !sgn && (dst_w >= op_w)) begin
      uns_wide_chk: assert (dout == (din & op_mask));
    end
  end

endmodule

// File: rtl/ldfmt_stage.sv
module ldfmt_stage
  import ldfmt_pkg::*;
#(
  parameter int unsigned DATA_W = LDF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        in_op_w,
  input  logic [1:0]        in_dst_w,
  input  logic              in_rev,
  input  logic              in_le,
  input  logic              in_sat,
  input  logic              in_signed,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  logic              do_swap;
  logic [DATA_W-1:0] ordered;
  logic [DATA_W-1:0] formatted;
  logic              valid_d, valid_q;
  logic [DATA_W-1:0] data_d, data_q;

  assign do_swap = ~(in_rev ^ in_le);

  ldfmt_swap #(.DATA_W(DATA_W)) u_swap (
    .din     (in_data),
    .op_w    (in_op_w),
    .do_swap (do_swap),
    .dout    (ordered)
  );

  ldfmt_conv #(.DATA_W(DATA_W)) u_conv (
    .din   (ordered),
    .op_w  (in_op_w),
    .dst_w (in_dst_w),
    .sat   (in_sat),
    .sgn   (in_signed),
    .dout  (formatted)
  );

  always_comb begin
    valid_d = in_valid;
    data_d  = in_valid ? formatted : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_data & ~ew_mask($past(in_dst_w))) == '0));
  // R4
  keep_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_rev != in_le) && !in_sat && (in_op_w == in_dst_w))
    |=> (out_data == ($past(in_data) & ew_mask($past(in_op_w)))));

endmodule

// File: tb/test_ldfmt_stage.sv
`timescale 1ns/1ps
module test_ldfmt_stage;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_data;
  logic [1:0]  in_op_w, in_dst_w;
  logic        in_rev, in_le, in_sat, in_signed;
  logic        out_valid;
  logic [63:0] out_data;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  ldfmt_stage i_ldfmt_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_op_w(in_op_w), .in_dst_w(in_dst_w), .in_rev(in_rev), .in_le(in_le),
    .in_sat(in_sat), .in_signed(in_signed),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference built from the requirement text (R3..R8).
  function automatic logic [63:0] model(input logic [63:0] d, input logic [1:0] op,
      input logic [1:0] dw, input logic rev, input logic le, input logic sat,
      input logic sgn);
    int n = 8 << op;
    int w = 8 << dw;
    int nb = n / 8;
    logic [63:0] v = '0;
    logic [63:0] r = '0;
    logic any_hi = 1'b0;
    longint sv, hi, lo;
    for (int k = 0; k < nb; k++) begin
      if (rev == le) v[8*k +: 8] = d[8*(nb-1-k) +: 8];
      else           v[8*k +: 8] = d[8*k +: 8];
    end
    if (!sat) begin
      for (int i = 0; i < w; i++) r[i] = v[i];
    end else if (!sgn) begin
      for (int i = w; i < 64; i++) any_hi |= v[i];
      for (int i = 0; i < w; i++) r[i] = any_hi ? 1'b1 : v[i];
    end else begin
      for (int i = n; i < 64; i++) v[i] = v[n-1];
      sv = longint'(v);
      if (w < 64) begin
        hi = (longint'(1) <<< (w-1)) - 1;
        lo = -hi - 1;
        if (sv > hi) sv = hi;
        if (sv < lo) sv = lo;
      end
      for (int i = 0; i < w; i++) r[i] = sv[i];
    end
    return r;
  endfunction

  task automatic apply(input logic [63:0] d, input logic [1:0] op, input logic [1:0] dw,
      input logic rev, input logic le, input logic sat, input logic sgn,
      input string req);
    logic [63:0] exp;
    in_valid = 1'b1; in_data = d; in_op_w = op; in_dst_w = dw;
    in_rev = rev; in_le = le; in_sat = sat; in_signed = sgn;
    exp = model(d, op, dw, rev, le, sat, sgn);
    @(negedge clk);
    check({req, " valid"}, {63'b0, out_valid}, 64'd1);
    check(req, out_data, exp);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] pats [8];
    logic [63:0] last;
    pats[0] = 64'h0000_0000_0000_0000;
    pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'h0123_4567_89AB_CDEF;
    pats[3] = 64'h8000_0000_0000_0080;
    pats[4] = 64'h7F7F_7F7F_7F7F_7F7F;
    pats[5] = 64'hC3A5_0080_7FFF_8001;
    pats[6] = 64'h00FF_8000_0000_7FFF;
    pats[7] = 64'hFEDC_BA98_0000_0001;

    rst_n = 1'b0; in_valid = 1'b1; in_data = '1; in_op_w = 2'd3; in_dst_w = 2'd3;
    in_rev = 1'b0; in_le = 1'b0; in_sat = 1'b0; in_signed = 1'b0;
    repeat (3) @(negedge clk);
    // R1: held in reset
    check("R1 valid", {63'b0, out_valid}, 64'd0);
    check("R1 data", out_data, 64'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: first clock after release with no input
    check("R1 valid after release", {63'b0, out_valid}, 64'd0);
    check("R1 data after release", out_data, 64'd0);

    // Directed corner cases
    apply(64'h0000_0000_0000_1234, 2'd1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, "R3 swap half");
    check("R3 value", out_data, 64'h3412);
    apply(64'hAAAA_0000_0000_1234, 2'd1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, "R4 keep half");
    check("R4 value", out_data, 64'h1234);
    apply(64'hFFFF_FFFF_0000_0080, 2'd0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, "R7 widen neg");
    check("R7 value", out_data, 64'hFF80);
    apply(64'h0000_0000_0001_0000, 2'd2, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, "R6 clamp max");
    check("R6 value", out_data, 64'hFFFF);
    apply(64'h0000_0000_8000_0000, 2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, "R7 clamp min");
    check("R7 min", out_data, 64'h80);
    apply(64'h0000_0000_0000_1FF, 2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R5 truncate");
    check("R5 value", out_data, 64'hFF);

    // R9: idle cycle with disturbed inputs
    last = out_data;
    in_valid = 1'b0; in_data = 64'h5555_5555_5555_5555; in_sat = 1'b1;
    in_op_w = 2'd3; in_dst_w = 2'd3;
    @(negedge clk);
    check("R9 hold data", out_data, last);
    check("R2 idle valid", {63'b0, out_valid}, 64'd0);

    // Exhaustive sweep of all mode combinations (R3..R8)
    for (int p = 0; p < 8; p++) begin
      for (int m = 0; m < 256; m++) begin
        logic [7:0] c;
        c = m[7:0];
        apply(pats[p], c[1:0], c[3:2], c[4], c[5], c[6], c[7], "R3-8 sweep");
      end
    end

    // Pseudo-random data over every mode
    begin
      logic [63:0] lf;
      lf = 64'h1D87_2B41_9C3E_5A07;
      for (int t = 0; t < 2000; t++) begin
        lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
        apply(lf ^ {lf[31:0], lf[63:32]}, lf[1:0], lf[3:2], lf[4], lf[5], lf[6], lf[7],
              "R5/R6/R7 random");
        if (lf[10:8] == 3'd0) begin
          last = out_data;
          in_valid = 1'b0; in_data = ~in_data;
          @(negedge clk);
          check("R9 random idle", out_data, last);
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule